// File: doc/BRIEF.md
# Reconfigurable Scan Test Wrapper

The wrapper places a core's scanned flip-flops between two test access wires. The flip-flops form two internal segments, A and B. The segments can be linked into one long wrapper chain fed from wire 0. They can also be run as two shorter chains loaded in parallel, A from wire 0 and B from wire 1. After reset, and whenever bypass is selected, the two test access wires pass straight through a single register.

A sequencer applies a sub-set of test vectors in the chain arrangement currently selected. Each vector is shifted in over a window of L cycles and then captured in one cycle. The response of a vector shifts out during the next vector's window. A final unload window empties the chains at the end of each sub-set. A counter of remaining vectors is kept between sub-sets. A test set can therefore be preempted, the chain arrangement changed while the sequencer is idle, and the rest of the vectors applied later at the other width.

The sequencer has four states. IDLE moves to SHIFT on an accepted start. SHIFT moves to CAPTURE after L cycles. CAPTURE returns to SHIFT while vectors of the sub-set remain, and otherwise moves to UNLOAD. UNLOAD returns to IDLE after L cycles and pulses `done`.

The scan cells model the core with a simple rule: on a capture cycle every cell inverts its own value.

Top module: `reconf_scan_wrap`

## Requirements
- R1: Synchronous reset selects bypass mode with the sequencer idle and `tam_out` at 0. In bypass, each `tam_in` bit appears on the same-index `tam_out` bit exactly one cycle later.
- R2: Mode code `cfg_sel`=2'b01 links the segments into one chain of SEG_A_LEN+SEG_B_LEN cells. Stimulus is taken only from `tam_in[0]` and the response leaves on `tam_out[0]`. `tam_out[1]` stays 0, and `tam_in[1]` has no effect.
- R3: Mode code 2'b10 runs two chains at once: segment A from `tam_in[0]` to `tam_out[0]`, and segment B from `tam_in[1]` to `tam_out[1]`.
- R4: Every vector is a window of L shift cycles followed by one capture cycle. During capture every scan cell inverts itself. During the following window each chain emits, in order, the inverse of the bits it took in during the previous window.
- R5: A sub-set of n vectors keeps `busy` high for exactly (n+1)·L + n cycles. L is SEG_A_LEN+SEG_B_LEN in one-chain mode and the longer segment in two-chain mode. `done` is high for exactly the one cycle after `busy` falls.
- R6: In two-chain mode the shorter segment holds still for the first (L − its length) cycles of every window. Both chains therefore finish each window on the same cycle, and wire bits offered during the idle cycles are ignored.
- R7: A mode write is rejected if it would give any chain fewer than MIN_CHAIN cells, and code 2'b11 is always rejected. A rejected write pulses `cfg_rej` for one cycle and leaves the mode unchanged. Code 2'b00 selects bypass.
- R8: A mode write while `busy` is high is ignored: the chains keep their current arrangement and `cfg_busy` pulses for one cycle.
- R9: The remaining-vector count starts at NUM_VEC and falls by one per capture. A start request uses min(`sub_cnt`, remaining). A start is ignored when `sub_cnt` is 0, when no vectors remain, or in bypass. `all_done` is high exactly when no vectors remain.
- R10: A test set may be split into sub-sets applied in different modes. The remaining count carries across the split, and each sub-set pays its own final unload window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tam_in | input | 2 | Test access input wires |
| tam_out | output | 2 | Test access output wires |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_sel | input | 2 | Mode code: 00 bypass, 01 one chain, 10 two chains |
| cfg_rej | output | 1 | One-cycle pulse: mode write rejected as illegal |
| cfg_busy | output | 1 | One-cycle pulse: mode write ignored while busy |
| start | input | 1 | Start a sub-set |
| sub_cnt | input | VEC_W | Vectors requested for the sub-set |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle pulse after a sub-set completes |
| all_done | output | 1 | No vectors of the test set remain |

## Verification
A wrong mode register shows up within one window as a response stream of the wrong length, or on the wrong wire. A miscounted window or sub-set counter shifts the `busy` fall and the `done` pulse by whole cycles, and it misaligns every inverted response bit of the next window. A corrupted remaining-vector count shows when a clipped sub-set ends early or late, or in `all_done`. Padding errors appear on the second wire as output changes during the first idle cycles of a window, followed by a shifted response stream.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
    typedef enum logic [1:0] {
        MODE_BYP = 2'b00,
        MODE_ONE = 2'b01,
        MODE_TWO = 2'b10
    } wmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPT,
        ST_UNLD
    } wstate_e;
endpackage

// File: rtl/wrap_cfg.sv
module wrap_cfg
    import wrap_pkg::*;
#(
    parameter int SEG_A   = 24,
    parameter int SEG_B   = 20,
    parameter int MIN_LEN = 20,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic             busy,
    output wmode_e           mode,
    output logic [CNT_W-1:0] win_len,
    output logic             cfg_rej,
    output logic             cfg_busy
);
    localparam int TOTAL  = SEG_A + SEG_B;
    localparam int MAXL   = (SEG_A > SEG_B) ? SEG_A : SEG_B;
    localparam bit ONE_OK = (TOTAL >= MIN_LEN);
    localparam bit TWO_OK = (SEG_A >= MIN_LEN) && (SEG_B >= MIN_LEN);

    wmode_e mode_q;
    logic   legal;

    always_comb begin
        unique case (cfg_sel)
            2'b00:   legal = 1'b1;
            2'b01:   legal = ONE_OK;
            2'b10:   legal = TWO_OK;
            default: legal = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_BYP;
            cfg_rej  <= 1'b0;
            cfg_busy <= 1'b0;
        end else begin
            cfg_rej  <= cfg_wr && !busy && !legal;
            cfg_busy <= cfg_wr && busy;
            if (cfg_wr && !busy && legal)
                mode_q <= wmode_e'(cfg_sel);
        end
    end

    always_comb begin
        unique case (mode_q)
            MODE_ONE: win_len = CNT_W'(TOTAL);
            MODE_TWO: win_len = CNT_W'(MAXL);
            default:  win_len = CNT_W'(1);
        endcase
    end

    assign mode = mode_q;

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && busy) |=> (cfg_busy && $stable(mode_q)));

    assert_rej_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !busy && !legal) |=> (cfg_rej && $stable(mode_q)));

    assert_frozen_run_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));
endmodule

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
    import wrap_pkg::*;
#(
    parameter int NUM_VEC = 10,
    parameter int VEC_W   = 4,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VEC_W-1:0] sub_cnt,
    input  wmode_e           mode,
    input  logic [CNT_W-1:0] win_len,
    output logic             shift_en,
    output logic             cap_en,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             done,
    output logic             all_done
);
    wstate_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [VEC_W-1:0] sub_q, rem_q, n_eff;
    logic             done_q, last, accept;

    assign last   = (cnt_q == CNT_W'(win_len - CNT_W'(1)));
    assign accept = start && (sub_cnt != '0) && (rem_q != '0) && (mode != MODE_BYP);
    assign n_eff  = (sub_cnt > rem_q) ? rem_q : sub_cnt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SHIFT;
            ST_SHIFT: if (last) state_d = ST_CAPT;
            ST_CAPT:  state_d = (sub_q == VEC_W'(1)) ? ST_UNLD : ST_SHIFT;
            ST_UNLD:  if (last) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sub_q   <= '0;
            rem_q   <= VEC_W'(NUM_VEC);
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_UNLD) && last;
            if ((state_q == ST_SHIFT) || (state_q == ST_UNLD))
                cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
            else
                cnt_q <= '0;
            if ((state_q == ST_IDLE) && accept)
                sub_q <= n_eff;
            if (state_q == ST_CAPT) begin
                sub_q <= sub_q - VEC_W'(1);
                rem_q <= rem_q - VEC_W'(1);
            end
        end
    end

    always_comb begin
        shift_en = (state_q == ST_SHIFT) || (state_q == ST_UNLD);
        cap_en   = (state_q == ST_CAPT);
        busy     = (state_q != ST_IDLE);
        cnt      = cnt_q;
        done     = done_q;
        all_done = (rem_q == '0);
    end

    assert_rem_falls_R9: assert property (@(posedge clk) disable iff (rst)
        rem_q <= $past(rem_q));

    assert_capt_has_vec_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPT) |-> (rem_q != '0));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == ST_IDLE));
endmodule

// File: rtl/wrap_chain.sv
module wrap_chain
    import wrap_pkg::*;
#(
    parameter int SEG_A = 24,
    parameter int SEG_B = 20,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  wmode_e           mode,
    input  logic             shift_en,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       tam_in,
    output logic [1:0]       tam_out
);
    localparam int TOTAL = SEG_A + SEG_B;
    localparam int MAXL  = (SEG_A > SEG_B) ? SEG_A : SEG_B;
    localparam int PAD_A = MAXL - SEG_A;
    localparam int PAD_B = MAXL - SEG_B;

    logic [TOTAL-1:0] cells;
    logic [1:0]       byp_q;
    logic             en_a, en_b;

    assign en_a = shift_en && (cnt >= CNT_W'(PAD_A));
    assign en_b = shift_en && (cnt >= CNT_W'(PAD_B));

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '0;
            byp_q <= '0;
        end else begin
            byp_q <= tam_in;
            if (cap_en) begin
                cells <= ~cells;
            end else if (shift_en && (mode == MODE_ONE)) begin
                cells <= {tam_in[0], cells[TOTAL-1:1]};
            end else if (mode == MODE_TWO) begin
                if (en_a) cells[SEG_A-1:0]     <= {tam_in[0], cells[SEG_A-1:1]};
                if (en_b) cells[TOTAL-1:SEG_A] <= {tam_in[1], cells[TOTAL-1:SEG_A+1]};
            end
        end
    end

    always_comb begin
        unique case (mode)
            MODE_ONE: tam_out = {1'b0, cells[0]};
            MODE_TWO: tam_out = {cells[SEG_A], cells[0]};
            default:  tam_out = byp_q;
        endcase
    end

    assert_pad_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_TWO) && shift_en && (cnt < CNT_W'(PAD_B)))
        |=> $stable(cells[TOTAL-1:SEG_A]));

    assert_bypass_cells_R1: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BYP) |=> $stable(cells));
endmodule

// File: rtl/reconf_scan_wrap.sv
module reconf_scan_wrap
    import wrap_pkg::*;
#(
    parameter int SEG_A_LEN = 24,
    parameter int SEG_B_LEN = 20,
    parameter int MIN_CHAIN = 20,
    parameter int NUM_VEC   = 10,
    parameter int VEC_W     = $clog2(NUM_VEC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       tam_in,
    output logic [1:0]       tam_out,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    output logic             cfg_rej,
    output logic             cfg_busy,
    input  logic             start,
    input  logic [VEC_W-1:0] sub_cnt,
    output logic             busy,
    output logic             done,
    output logic             all_done
);
    localparam int CNT_W = $clog2(SEG_A_LEN + SEG_B_LEN + 1);

    wmode_e           mode;
    logic [CNT_W-1:0] win_len, cnt;
    logic             shift_en, cap_en;

    wrap_cfg #(.SEG_A(SEG_A_LEN), .SEG_B(SEG_B_LEN), .MIN_LEN(MIN_CHAIN), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .busy(busy),
        .mode(mode), .win_len(win_len), .cfg_rej(cfg_rej), .cfg_busy(cfg_busy)
    );

    wrap_ctrl #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .sub_cnt(sub_cnt), .mode(mode),
        .win_len(win_len), .shift_en(shift_en), .cap_en(cap_en), .cnt(cnt),
        .busy(busy), .done(done), .all_done(all_done)
    );

    wrap_chain #(.SEG_A(SEG_A_LEN), .SEG_B(SEG_B_LEN), .CNT_W(CNT_W)) u_chain (
        .clk(clk), .rst(rst), .mode(mode), .shift_en(shift_en), .cap_en(cap_en),
        .cnt(cnt), .tam_in(tam_in), .tam_out(tam_out)
    );

    assert_one_wire1_low_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ONE) |-> (tam_out[1] == 1'b0));

    assert_bypass_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BYP) |-> !shift_en);
endmodule

// File: tb/sim_reconf_scan_wrap.sv
`timescale 1ns/1ps
module sim_reconf_scan_wrap;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    logic [1:0] tin, tout, tin1, tout1;
    logic       wr, wr1, rej, rej1, bsyf, bsyf1, st, st1, busy, busy1, dn, dn1, ad, ad1;
    logic [1:0] sel, sel1;
    logic [3:0] sc, sc1;

    int nchk = 0;
    int nfail = 0;

    reconf_scan_wrap u0 (
        .clk(clk), .rst(rst), .tam_in(tin), .tam_out(tout), .cfg_wr(wr), .cfg_sel(sel),
        .cfg_rej(rej), .cfg_busy(bsyf), .start(st), .sub_cnt(sc), .busy(busy),
        .done(dn), .all_done(ad)
    );

    reconf_scan_wrap #(.SEG_B_LEN(16)) u1 (
        .clk(clk), .rst(rst), .tam_in(tin1), .tam_out(tout1), .cfg_wr(wr1), .cfg_sel(sel1),
        .cfg_rej(rej1), .cfg_busy(bsyf1), .start(st1), .sub_cnt(sc1), .busy(busy1),
        .done(dn1), .all_done(ad1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bypass_check(input bit inst, input string req);
        logic [1:0] v;
        for (int k = 0; k < 8; k++) begin
            v = 2'($urandom);
            if (inst) tin1 = v; else tin = v;
            @(negedge clk);
            if (inst) chk(tout1 == v, req, tout1, v);
            else      chk(tout == v, req, tout, v);
        end
    endtask

    task automatic do_cfg(input bit inst, input logic [1:0] code, input bit exp_rej);
        @(negedge clk);
        if (inst) begin wr1 = 1'b1; sel1 = code; end
        else      begin wr = 1'b1; sel = code; end
        @(negedge clk);
        wr = 1'b0; wr1 = 1'b0;
        if (inst) chk(rej1 == exp_rej, "R7 cfg_rej", rej1, exp_rej);
        else      chk(rej == exp_rej, "R7 cfg_rej", rej, exp_rej);
    endtask

    task automatic start_ignored(input int n, input string req);
        @(negedge clk);
        st = 1'b1; sc = 4'(n);
        @(negedge clk);
        st = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(busy == 1'b0, req, busy, 0);
            @(negedge clk);
        end
    endtask

    // Apply one sub-set; neff is the count expected after clipping.
    task automatic run_sub(input int nreq, input int neff, input bit dual, input bit inj);
        int L, pad, busy_bad, bad_a, bad_b, bad_z, bad_pad;
        logic [63:0] pa, pb, ca, cb, oa, ob;
        L   = dual ? 24 : 44;
        pad = dual ? 4 : 0;
        busy_bad = 0;
        pa = '0; pb = '0;
        @(negedge clk);
        st = 1'b1; sc = 4'(nreq);
        @(negedge clk);
        st = 1'b0;
        for (int w = 0; w <= neff; w++) begin
            bad_a = 0; bad_b = 0; bad_z = 0; bad_pad = 0;
            for (int j = 0; j < L; j++) begin
                if (!busy) busy_bad++;
                oa[j] = tout[0];
                ob[j] = tout[1];
                ca[j] = 1'($urandom);
                cb[j] = 1'($urandom);
                tin = {cb[j], ca[j]};
                if (inj && w == 1 && j == 3) begin wr = 1'b1; sel = 2'b10; end
                if (inj && w == 1 && j == 4) begin
                    wr = 1'b0;
                    chk(bsyf == 1'b1, "R8 cfg_busy pulse", bsyf, 1);
                end
                @(negedge clk);
            end
            for (int p = 0; p < L; p++) begin
                if (w >= 1 && oa[p] != ~pa[p]) bad_a++;
                if (dual && w >= 1 && p >= pad && ob[p] != ~pb[p]) bad_b++;
                if (!dual && ob[p] != 1'b0) bad_z++;
                if (dual && p < pad && ob[p] != ob[pad]) bad_pad++;
            end
            if (w >= 1) chk(bad_a == 0, dual ? "R3 R4 wire0 response" : "R2 R4 chain response", bad_a, 0);
            if (dual && w >= 1) chk(bad_b == 0, "R3 R4 R6 wire1 response", bad_b, 0);
            if (!dual) chk(bad_z == 0, "R2 wire1 low", bad_z, 0);
            if (dual) chk(bad_pad == 0, "R6 pad hold", bad_pad, 0);
            pa = ca; pb = cb;
            if (w < neff) begin
                if (!busy) busy_bad++;
                @(negedge clk);
            end
        end
        chk(busy_bad == 0 && busy == 1'b0, "R5 R10 busy span", busy_bad, 0);
        chk(dn == 1'b1, "R5 done pulse", dn, 1);
        @(negedge clk);
        chk(dn == 1'b0, "R5 done single", dn, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        rst = 1'b1; tin = '0; tin1 = '0; wr = 0; wr1 = 0; sel = '0; sel1 = '0;
        st = 0; st1 = 0; sc = '0; sc1 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tout == 2'b00, "R1 reset out", tout, 0);
        chk(busy == 1'b0 && dn == 1'b0 && ad == 1'b0, "R1 reset idle", busy, 0);
        bypass_check(1'b0, "R1 bypass pass");
        start_ignored(3, "R9 start in bypass");

        do_cfg(1'b0, 2'b01, 1'b0);
        start_ignored(0, "R9 zero sub_cnt");
        run_sub(3, 3, 1'b0, 1'b1);
        chk(ad == 1'b0, "R9 all_done low", ad, 0);

        do_cfg(1'b0, 2'b10, 1'b0);
        run_sub(4, 4, 1'b1, 1'b0);
        chk(ad == 1'b0, "R10 remaining kept", ad, 0);

        do_cfg(1'b0, 2'b11, 1'b1);
        run_sub(9, 3, 1'b1, 1'b0);
        chk(ad == 1'b1, "R9 R10 all_done", ad, 1);
        start_ignored(2, "R9 start with none left");

        do_cfg(1'b0, 2'b00, 1'b0);
        bypass_check(1'b0, "R1 bypass again");

        do_cfg(1'b1, 2'b10, 1'b1);
        bypass_check(1'b1, "R7 mode kept after reject");
        do_cfg(1'b1, 2'b01, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule